// File: doc/BRIEF.md
# Four-Bit Arithmetic Logic Unit with Status Flags

This block is a purely combinational arithmetic logic unit. It takes two 4-bit operands and a 3-bit operation code. It returns a 4-bit result and four status flags: zero, negative, carry and signed overflow. It is meant to sit inside a small datapath, for example beside an accumulator. The surrounding logic presents operands and an operation in a cycle and captures the outputs at the next edge.

Addition and subtraction share a single ripple chain of 1-bit full adders. For subtraction, the second operand is inverted bit by bit through XOR gates driven by a subtract strobe, and the same strobe is injected as the carry into the least significant stage. This yields the two's complement difference. The bitwise AND, OR and XOR units run in parallel. An output multiplexer, steered by strobes that a small decoder derives from the operation code, picks one unit's result. Operation codes with no assigned operation return a fixed, all-clear output.

Top module: `alu4`

## Requirements
- R1: Operation code 000 (add) gives result = (A + B) mod 16, and carry equals the fifth bit of the unsigned sum.
- R2: Operation code 001 (subtract) gives result = (A - B) mod 16, and carry is 1 exactly when A >= B as unsigned numbers (no borrow).
- R3: For codes 000 and 001, overflow is 1 exactly when the true signed (two's complement, -8..7) sum or difference falls outside -8..7.
- R4: Codes 010, 011 and 100 give the bitwise AND, OR and XOR of A and B respectively, with carry and overflow both 0.
- R5: For codes 000 to 100, the zero flag is 1 exactly when the 4-bit result is 0000.
- R6: For codes 000 to 100, the negative flag equals bit 3 of the result.
- R7: Codes 101, 110 and 111 give result 0000 with zero, negative, carry and overflow all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand (subtrahend for subtract) |
| opSel | input | 3 | Operation code |
| result | output | 4 | Selected operation result |
| flagZero | output | 1 | Result is all zeros (valid codes only) |
| flagNeg | output | 1 | Copy of result bit 3 (valid codes only) |
| flagCarry | output | 1 | Adder carry out; no-borrow for subtract |
| flagOvf | output | 1 | Signed overflow for add and subtract |

## Verification
Carry and signed overflow can both be raised by one add or subtract, and the zero flag can rise alongside them when the wrapped result is 0000. Adding 1000 to 1000 provokes all three at once, and 1000 minus 0001 provokes carry with overflow and a positive result. The bench sweeps every operand pair for every code and judges all four flags and the result together against a model built on integer arithmetic. It also runs named corner cases that exercise these coincidences.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100
  } opcode_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic subtract;  // invert B and inject carry-in
    logic arith;     // adder result selected, arithmetic flags live
    logic useAnd;
    logic useOr;
    logic useXor;
    logic valid;     // code maps to an operation
  } alu_ctrl_t;

endpackage

// File: rtl/alu4_full_adder.sv
module alu4_full_adder (
  input  logic bitA,
  input  logic bitB,
  input  logic carryIn,
  output logic sumBit,
  output logic carryOut
);
  logic halfSum;

  always_comb begin
    halfSum  = bitA ^ bitB;
    sumBit   = halfSum ^ carryIn;
    carryOut = (bitA & bitB) | (halfSum & carryIn);
  end
endmodule

// File: rtl/alu4_ctrl.sv
module alu4_ctrl
  import alu4_pkg::*;
(
  input  logic [2:0] opSel,
  output alu_ctrl_t  ctrl
);
  always_comb begin
    ctrl = '0;
    case (opSel)
      OP_ADD: begin ctrl.arith = 1'b1; ctrl.valid = 1'b1; end
      OP_SUB: begin ctrl.arith = 1'b1; ctrl.subtract = 1'b1; ctrl.valid = 1'b1; end
      OP_AND: begin ctrl.useAnd = 1'b1; ctrl.valid = 1'b1; end
      OP_OR:  begin ctrl.useOr = 1'b1; ctrl.valid = 1'b1; end
      OP_XOR: begin ctrl.useXor = 1'b1; ctrl.valid = 1'b1; end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/alu4_datapath.sv
module alu4_datapath
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] result,
  output logic             flagZero,
  output logic             flagNeg,
  output logic             flagCarry,
  output logic             flagOvf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bAdj;
  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] sumVec;
  logic [WIDTH-1:0] andVec;
  logic [WIDTH-1:0] orVec;
  logic [WIDTH-1:0] xorVec;

  always_comb begin
    bAdj          = opB ^ {WIDTH{ctrl.subtract}};
    carryChain[0] = ctrl.subtract;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    alu4_full_adder u_fa (
      .bitA    (opA[i]),
      .bitB    (bAdj[i]),
      .carryIn (carryChain[i]),
      .sumBit  (sumVec[i]),
      .carryOut(carryChain[i+1])
    );
  end

  always_comb begin
    andVec = opA & opB;
    orVec  = opA | opB;
    xorVec = opA ^ opB;
  end

  always_comb begin
    result = '0;
    if (ctrl.arith)       result = sumVec;
    else if (ctrl.useAnd) result = andVec;
    else if (ctrl.useOr)  result = orVec;
    else if (ctrl.useXor) result = xorVec;
  end

  always_comb begin
    flagZero  = ctrl.valid & (result == '0);
    flagNeg   = ctrl.valid & result[MSB];
    flagCarry = ctrl.arith & carryChain[WIDTH];
    flagOvf   = ctrl.arith & (carryChain[WIDTH] ^ carryChain[MSB]);
  end
endmodule

// File: rtl/alu4.sv
module alu4
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             flagZero,
  output logic             flagNeg,
  output logic             flagCarry,
  output logic             flagOvf
);
  alu_ctrl_t ctrl;

  alu4_ctrl u_ctrl (
    .opSel(opSel),
    .ctrl (ctrl)
  );

  alu4_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .flagZero (flagZero),
    .flagNeg  (flagNeg),
    .flagCarry(flagCarry),
    .flagOvf  (flagOvf)
  );
endmodule

// File: rtl/alu4_checker.sv
module alu4_checker #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       opSel,
  input logic [WIDTH-1:0] result,
  input logic             flagZero,
  input logic             flagNeg,
  input logic             flagCarry,
  input logic             flagOvf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wideSum;
  logic [WIDTH:0] wideDiff;
  logic           validCode;

  always_comb begin
    wideSum   = {1'b0, opA} + {1'b0, opB};
    wideDiff  = {1'b1, opA} - {1'b0, opB};
    validCode = (opSel <= 3'd4);

    if (opSel == 3'd0) begin
      assert_add_sum_R1: assert ({flagCarry, result} == wideSum)
        else $error("add sum/carry mismatch");
      assert_add_ovf_R3: assert (flagOvf == ((opA[MSB] == opB[MSB]) && (result[MSB] != opA[MSB])))
        else $error("add overflow mismatch");
    end
    if (opSel == 3'd1) begin
      assert_sub_diff_R2: assert ({flagCarry, result} == wideDiff)
        else $error("sub difference/borrow mismatch");
      assert_sub_ovf_R3: assert (flagOvf == ((opA[MSB] != opB[MSB]) && (result[MSB] != opA[MSB])))
        else $error("sub overflow mismatch");
    end
    if (opSel >= 3'd2 && opSel <= 3'd4) begin
      assert_logic_flags_R4: assert (!flagCarry && !flagOvf)
        else $error("logic op raised carry or overflow");
    end
    if (validCode) begin
      assert_zero_flag_R5: assert (flagZero == (result == '0))
        else $error("zero flag mismatch");
      assert_neg_flag_R6: assert (flagNeg == result[MSB])
        else $error("negative flag mismatch");
    end else begin
      assert_unused_code_R7: assert (result == '0 && !flagZero && !flagNeg && !flagCarry && !flagOvf)
        else $error("unused code output not cleared");
    end
  end
endmodule

bind alu4 alu4_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu4_tb.sv
module alu4_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic [2:0] opSel = '0;
  logic [3:0] result;
  logic       flagZero, flagNeg, flagCarry, flagOvf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu4 u_dut (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .flagZero(flagZero), .flagNeg(flagNeg),
    .flagCarry(flagCarry), .flagOvf(flagOvf)
  );

  // Drive on the rising edge, judge on the falling edge
  task automatic checkVec(input logic [2:0] op, input logic [3:0] a,
                          input logic [3:0] b, input string tag);
    int sa, sb, sr, ua, ub;
    logic [3:0] eRes;
    logic eZ, eN, eC, eV, valid;
    @(posedge clk);
    opSel = op; opA = a; opB = b;
    @(negedge clk);
    ua = int'(a); ub = int'(b);
    sa = (ua > 7) ? ua - 16 : ua;
    sb = (ub > 7) ? ub - 16 : ub;
    eC = 1'b0; eV = 1'b0; valid = 1'b1; eRes = '0;
    case (op)
      3'd0: begin eRes = 4'((ua + ub) % 16); eC = (ua + ub) > 15;
                  sr = sa + sb; eV = (sr > 7) || (sr < -8); end
      3'd1: begin eRes = 4'((ua - ub + 16) % 16); eC = (ua >= ub);
                  sr = sa - sb; eV = (sr > 7) || (sr < -8); end
      3'd2: eRes = a & b;
      3'd3: eRes = a | b;
      3'd4: eRes = a ^ b;
      default: valid = 1'b0;
    endcase
    eZ = valid && (eRes == 4'd0);
    eN = valid && eRes[3];
    checks++;
    if (result !== eRes || flagZero !== eZ || flagNeg !== eN ||
        flagCarry !== eC || flagOvf !== eV) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual res=%0d z%0b n%0b c%0b v%0b expected res=%0d z%0b n%0b c%0b v%0b",
               tag, op, a, b, result, flagZero, flagNeg, flagCarry, flagOvf,
               eRes, eZ, eN, eC, eV);
    end
  endtask

  task automatic sweepOp(input logic [2:0] op, input string tag);
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        checkVec(op, 4'(a), 4'(b), tag);
  endtask

  task automatic testAdd();      sweepOp(3'd0, "R1 R3 R5 R6"); endtask
  task automatic testSub();      sweepOp(3'd1, "R2 R3 R5 R6"); endtask
  task automatic testLogic();
    sweepOp(3'd2, "R4 and");
    sweepOp(3'd3, "R4 or");
    sweepOp(3'd4, "R4 xor");
  endtask
  task automatic testUnused();
    for (int op = 5; op < 8; op++) sweepOp(3'(op), "R7");
  endtask
  task automatic testCorners();
    checkVec(3'd0, 4'h8, 4'h8, "R1 R3 R5 carry+ovf+zero");
    checkVec(3'd0, 4'h7, 4'h1, "R3 positive ovf");
    checkVec(3'd1, 4'h8, 4'h1, "R2 R3 carry+ovf");
    checkVec(3'd1, 4'h0, 4'h0, "R2 R5 zero no borrow");
    checkVec(3'd1, 4'h0, 4'h1, "R2 R6 borrow negative");
    checkVec(3'd2, 4'hF, 4'h0, "R4 R5 and zero");
    checkVec(3'd7, 4'hF, 4'hF, "R7 unused all-ones");
  endtask

  initial begin
    testCorners();
    testAdd();
    testSub();
    testLogic();
    testUnused();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule